// File: doc/BRIEF.md
# Polled Command Exchange Sequencer for a Security Coprocessor

This block is a host-side master that carries out one full command/response exchange with a security coprocessor through its byte-wide register window, by polling alone. A single start pulse makes it claim locality 0, make sure the device will accept a command (aborting any work in progress if it will not), and push the command bytes out. It then triggers execution and collects the reply into a local buffer. Each wait on a device flag is bounded by a cycle-counted time window, and each way the exchange can fail gives its own error code.

Register access uses a one-cycle strobe. `bus_rd` or `bus_wr` is high for one cycle with `bus_addr`. For a read, the device returns `bus_rdata` in the following cycle, and the sequencer samples it there. The command is presented as a flat byte vector, with byte 0 in bits 7:0. It must stay stable, together with `cmd_len`, `rsp_len` and `hdr_only`, from `start` until `done`.

Top module: `tpm_xfer_seq`

## Requirements
- R1: After reset, `done` is 0, `err` is 0, `rsp_count` is 0, and neither `bus_rd` nor `bus_wr` is asserted until `start`.
- R2: The block reads address 0x00. If bit 7 (valid) and bit 5 (locality active) are not both set, it writes 0x02 to 0x00 once and polls 0x00 until both bits are set. If both are already set, it writes nothing to 0x00.
- R3: If the locality poll does not succeed within the short window, the exchange ends with `err` = 1.
- R4: The block reads status at 0x18. If bit 6 (ready) is clear, it writes 0x40 to 0x18 and polls until bit 6 sets. If the long window expires first, `err` = 2 and no command byte is written.
- R5: The burst count is read as two single bytes, 0x19 (low) and 0x1A (high), and combined little-endian. While the result is zero the read pair is repeated. If the count stays zero for the short window, `err` = 6.
- R6: Every command byte except the last is written to 0x24, in order. Each chunk holds no more bytes than the burst count last read. After each chunk, status is polled until bits 7 and 3 (expect) are both set. If the long window expires first, `err` = 3.
- R7: The last byte is written on its own, after that poll and without a new burst read. Status is then polled for bit 7. If bit 3 is still set, `err` = 4 and no go is issued. Otherwise 0x20 is written to 0x18.
- R8: For the reply, status is polled until bits 4 (data available) and 7 are set. Then up to the burst count of bytes are read from 0x24, and the cycle repeats until `rsp_len` bytes (capped at MAX_RSP) are held. Byte k appears at `rsp_bytes[8k+7:8k]`. If the long window expires while polling, `err` = 5.
- R9: With `hdr_only` set, collection stops at the end of the first reply chunk that brings the count to at least 6.
- R10: The short window is SHORT_MS×CYC_PER_MS cycles and the long window is LONG_MS×CYC_PER_MS cycles, each counted from the start of its wait.
- R11: `done` is high for exactly one cycle per exchange. `err` is 0 on success and holds its value until the next `start`.
- R12: A one-byte command skips the burst read and the chunk loop, and its byte goes out as the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange (taken while idle) |
| cmd_bytes | input | MAX_CMD*8 | Command bytes, byte 0 in bits 7:0 |
| cmd_len | input | CMD_W | Number of command bytes (at least 1) |
| rsp_len | input | RSP_W | Reply bytes wanted |
| hdr_only | input | 1 | Stop once a chunk leaves at least 6 reply bytes |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| rsp_bytes | output | MAX_RSP*8 | Collected reply, byte 0 in bits 7:0 |
| rsp_count | output | RSP_W | Number of reply bytes collected |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result code: 0 ok, 1 locality, 2 ready, 3 expect wait, 4 expect still set, 5 reply wait, 6 burst |

## Verification
The save-state command is run against a device model under these conditions:
- **Fast path and slow path.** In the fast path, locality is already held and the device is ready. In the slow path, it needs both the locality request and the abort, and its burst count is zero for some reads and then has only the high byte set. Together these separate the skip logic from the request logic, and catch a burst combined from the wrong byte.
- **Burst of four, full versus header-only.** A burst of four with a full reply gives 10 bytes, while header-only gives 8. This separates chunk-end stopping from per-byte stopping.
- **Fault injection.** One device model is set to never grant, one never gets ready, one never shows expect, one leaves expect set at the end, one never has data, and one never reports a burst. Each must map to its own code, with the bus traffic stopping at the right place.
- **One-byte command.** This checks that the chunk loop is bypassed.

// File: rtl/tpm_xfer_pkg.sv
package tpm_xfer_pkg;
    // register byte addresses in the device window
    localparam logic [7:0] A_ACCESS = 8'h00;
    localparam logic [7:0] A_STS    = 8'h18;
    localparam logic [7:0] A_BST_LO = 8'h19;
    localparam logic [7:0] A_BST_HI = 8'h1A;
    localparam logic [7:0] A_FIFO   = 8'h24;

    localparam logic [7:0] ACC_VALID  = 8'h80;
    localparam logic [7:0] ACC_ACTIVE = 8'h20;
    localparam logic [7:0] ACC_REQ    = 8'h02;

    localparam logic [7:0] ST_VALID  = 8'h80;
    localparam logic [7:0] ST_READY  = 8'h40;
    localparam logic [7:0] ST_GO     = 8'h20;
    localparam logic [7:0] ST_AVAIL  = 8'h10;
    localparam logic [7:0] ST_EXPECT = 8'h08;

    localparam int HDR_MIN = 6;

    typedef enum logic [4:0] {
        S_IDLE, S_LOC_CHK, S_LOC_REQ, S_LOC_POLL, S_RDY_CHK, S_ABORT,
        S_RDY_POLL, S_BST_LO, S_BST_HI, S_SEND, S_EXP_POLL, S_LAST,
        S_FIN_POLL, S_GO, S_RSP_POLL, S_RECV
    } seq_state_t;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_LOC_TMO = 3'd1,
        E_RDY_TMO = 3'd2,
        E_EXP_TMO = 3'd3,
        E_EXP_SET = 3'd4,
        E_RSP_TMO = 3'd5,
        E_BST_TMO = 3'd6
    } seq_err_t;
endpackage

// File: rtl/tpm_xfer_timer.sv
module tpm_xfer_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // a freshly loaded window never reads as expired in the next cycle
    p_load_fresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/tpm_xfer_seq.sv
module tpm_xfer_seq
    import tpm_xfer_pkg::*;
#(
    parameter int MAX_CMD    = 16,
    parameter int MAX_RSP    = 16,
    parameter int CYC_PER_MS = 100000,
    parameter int SHORT_MS   = 2000,
    parameter int LONG_MS    = 120000,
    localparam int CMD_W = $clog2(MAX_CMD + 1),
    localparam int RSP_W = $clog2(MAX_RSP + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MAX_CMD*8-1:0] cmd_bytes,
    input  logic [CMD_W-1:0]     cmd_len,
    input  logic [RSP_W-1:0]     rsp_len,
    input  logic                 hdr_only,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic [7:0]           bus_addr,
    output logic [7:0]           bus_wdata,
    input  logic [7:0]           bus_rdata,
    output logic [MAX_RSP*8-1:0] rsp_bytes,
    output logic [RSP_W-1:0]     rsp_count,
    output logic                 done,
    output logic [2:0]           err
);
    localparam longint unsigned SHORT_CYC = longint'(SHORT_MS) * longint'(CYC_PER_MS);
    localparam longint unsigned LONG_CYC  = longint'(LONG_MS) * longint'(CYC_PER_MS);
    localparam int TMR_W = $clog2(LONG_CYC + 1) + 1;
    localparam logic [TMR_W-1:0] T_SHORT = TMR_W'(SHORT_CYC);
    localparam logic [TMR_W-1:0] T_LONG  = TMR_W'(LONG_CYC);

    typedef struct packed {
        seq_state_t                st;
        logic                      ph;    // 0: issue read, 1: evaluate
        logic                      rx;    // burst read serves the reply
        logic [CMD_W-1:0]          sent;
        logic [15:0]               bst;
        logic [7:0]                blo;
        logic [RSP_W-1:0]          rcnt;
        logic [MAX_RSP-1:0][7:0]   rbuf;
        seq_err_t                  err;
        logic                      done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic [CMD_W-1:0] last_idx;
    logic [RSP_W-1:0] rlim, rnext;
    logic [15:0]      bst_rd;

    assign last_idx = (cmd_len == '0) ? '0 : cmd_len - 1'b1;
    assign rlim     = (rsp_len > RSP_W'(MAX_RSP)) ? RSP_W'(MAX_RSP) : rsp_len;
    assign rnext    = seq_q.rcnt + 1'b1;
    assign bst_rd   = {bus_rdata, seq_q.blo};

    tpm_xfer_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_addr   = A_ACCESS;
        bus_wdata  = 8'h00;
        tmr_load   = 1'b0;
        tmr_val    = T_SHORT;
        case (seq_q.st)
            S_IDLE: if (start) begin
                seq_d.st = S_LOC_CHK; seq_d.ph = 1'b0; seq_d.sent = '0;
                seq_d.rcnt = '0; seq_d.rbuf = '0; seq_d.err = E_NONE;
            end
            S_LOC_CHK, S_LOC_POLL: begin
                bus_addr = A_ACCESS;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if ((bus_rdata & (ACC_VALID | ACC_ACTIVE)) == (ACC_VALID | ACC_ACTIVE))
                        seq_d.st = S_RDY_CHK;
                    else if (seq_q.st == S_LOC_CHK)
                        seq_d.st = S_LOC_REQ;
                    else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_LOC_TMO; seq_d.done = 1'b1;
                    end
                end
            end
            S_LOC_REQ: begin
                bus_wr = 1'b1; bus_addr = A_ACCESS; bus_wdata = ACC_REQ;
                tmr_load = 1'b1; tmr_val = T_SHORT; seq_d.st = S_LOC_POLL;
            end
            S_RDY_CHK, S_RDY_POLL: begin
                bus_addr = A_STS;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if ((bus_rdata & ST_READY) != 8'h00) begin
                        if (cmd_len > CMD_W'(1)) begin
                            seq_d.st = S_BST_LO; seq_d.rx = 1'b0;
                            tmr_load = 1'b1; tmr_val = T_SHORT;
                        end else
                            seq_d.st = S_LAST;
                    end else if (seq_q.st == S_RDY_CHK)
                        seq_d.st = S_ABORT;
                    else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_RDY_TMO; seq_d.done = 1'b1;
                    end
                end
            end
            S_ABORT: begin
                bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = ST_READY;
                tmr_load = 1'b1; tmr_val = T_LONG; seq_d.st = S_RDY_POLL;
            end
            S_BST_LO: begin
                bus_addr = A_BST_LO;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin seq_d.ph = 1'b0; seq_d.blo = bus_rdata; seq_d.st = S_BST_HI; end
            end
            S_BST_HI: begin
                bus_addr = A_BST_HI;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if (bst_rd != 16'h0000) begin
                        seq_d.bst = bst_rd;
                        seq_d.st  = seq_q.rx ? S_RECV : S_SEND;
                    end else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_BST_TMO; seq_d.done = 1'b1;
                    end else
                        seq_d.st = S_BST_LO;
                end
            end
            S_SEND: begin
                bus_wr = 1'b1; bus_addr = A_FIFO;
                bus_wdata = cmd_bytes[seq_q.sent*8 +: 8];
                seq_d.sent = seq_q.sent + 1'b1;
                seq_d.bst  = seq_q.bst - 1'b1;
                if (seq_q.bst == 16'd1 || (seq_q.sent + 1'b1) == last_idx) begin
                    seq_d.st = S_EXP_POLL; tmr_load = 1'b1; tmr_val = T_LONG;
                end
            end
            S_EXP_POLL: begin
                bus_addr = A_STS;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if ((bus_rdata & (ST_VALID | ST_EXPECT)) == (ST_VALID | ST_EXPECT)) begin
                        if (seq_q.sent < last_idx) begin
                            seq_d.st = S_BST_LO; seq_d.rx = 1'b0;
                            tmr_load = 1'b1; tmr_val = T_SHORT;
                        end else
                            seq_d.st = S_LAST;
                    end else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_EXP_TMO; seq_d.done = 1'b1;
                    end
                end
            end
            S_LAST: begin
                bus_wr = 1'b1; bus_addr = A_FIFO;
                bus_wdata = cmd_bytes[last_idx*8 +: 8];
                tmr_load = 1'b1; tmr_val = T_LONG; seq_d.st = S_FIN_POLL;
            end
            S_FIN_POLL: begin
                bus_addr = A_STS;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if ((bus_rdata & ST_VALID) != 8'h00) begin
                        if ((bus_rdata & ST_EXPECT) != 8'h00) begin
                            seq_d.st = S_IDLE; seq_d.err = E_EXP_SET; seq_d.done = 1'b1;
                        end else
                            seq_d.st = S_GO;
                    end else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_EXP_TMO; seq_d.done = 1'b1;
                    end
                end
            end
            S_GO: begin
                bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = ST_GO;
                if (rlim == '0) begin
                    seq_d.st = S_IDLE; seq_d.done = 1'b1;
                end else begin
                    seq_d.st = S_RSP_POLL; tmr_load = 1'b1; tmr_val = T_LONG;
                end
            end
            S_RSP_POLL: begin
                bus_addr = A_STS;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    if ((bus_rdata & (ST_VALID | ST_AVAIL)) == (ST_VALID | ST_AVAIL)) begin
                        seq_d.st = S_BST_LO; seq_d.rx = 1'b1;
                        tmr_load = 1'b1; tmr_val = T_SHORT;
                    end else if (tmr_exp) begin
                        seq_d.st = S_IDLE; seq_d.err = E_RSP_TMO; seq_d.done = 1'b1;
                    end
                end
            end
            S_RECV: begin
                bus_addr = A_FIFO;
                if (!seq_q.ph) begin bus_rd = 1'b1; seq_d.ph = 1'b1; end
                else begin
                    seq_d.ph = 1'b0;
                    seq_d.rbuf[seq_q.rcnt] = bus_rdata;
                    seq_d.rcnt = rnext;
                    seq_d.bst  = seq_q.bst - 1'b1;
                    if (rnext == rlim ||
                        (seq_q.bst == 16'd1 && hdr_only && rnext >= RSP_W'(HDR_MIN))) begin
                        seq_d.st = S_IDLE; seq_d.done = 1'b1;
                    end else if (seq_q.bst == 16'd1) begin
                        seq_d.st = S_RSP_POLL; tmr_load = 1'b1; tmr_val = T_LONG;
                    end
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rsp_bytes = seq_q.rbuf;
    assign rsp_count = seq_q.rcnt;
    assign done      = seq_q.done;
    assign err       = seq_q.err;

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_IDLE && start) |=> (rsp_count == '0 && err == 3'd0));
    p_send_chunk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FIFO && seq_q.st == S_SEND) |-> seq_q.bst != 16'd0);
    p_recv_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_FIFO) |-> (seq_q.bst != 16'd0 && seq_q.rcnt < rlim));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_IDLE) |-> !(bus_rd || bus_wr));
endmodule

// File: tb/tpm_xfer_seq_test.sv
module tpm_xfer_seq_test;
    localparam int MAXC = 16;
    localparam int MAXR = 16;
    localparam int CW = $clog2(MAXC + 1);
    localparam int RW = $clog2(MAXR + 1);
    localparam int SHORT_T = 20;
    localparam int LONG_T  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [MAXC*8-1:0] cmd_bytes;
    logic [CW-1:0] cmd_len = '0;
    logic [RW-1:0] rsp_len = '0;
    logic hdr_only = 1'b0;
    logic bus_rd, bus_wr, done;
    logic [7:0] bus_addr, bus_wdata, dev_rdata;
    logic [MAXR*8-1:0] rsp_bytes;
    logic [RW-1:0] rsp_count;
    logic [2:0] err;

    always #4 clk = ~clk;

    tpm_xfer_seq #(.MAX_CMD(MAXC), .MAX_RSP(MAXR), .CYC_PER_MS(1),
                   .SHORT_MS(SHORT_T), .LONG_MS(LONG_T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_bytes(cmd_bytes),
        .cmd_len(cmd_len), .rsp_len(rsp_len), .hdr_only(hdr_only),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(dev_rdata), .rsp_bytes(rsp_bytes), .rsp_count(rsp_count),
        .done(done), .err(err)
    );

    logic [7:0] cmd_src [MAXC];
    always_comb for (int i = 0; i < MAXC; i++) cmd_bytes[8*i +: 8] = cmd_src[i];

    // device model configuration (written by tasks only)
    logic cfg_active0, cfg_grant, cfg_ready0, cfg_abort_ok, cfg_rsp_en;
    logic [15:0] cfg_burst;
    int cfg_zero_reads, cfg_exp_len, cfg_rsp_n;
    logic [7:0] rsp_mem [MAXR];
    logic dev_clr = 1'b0;

    // device model state
    logic d_active, d_ready, d_go, d_req, d_abort, d_chunk_bad;
    int d_nrx, d_ridx, d_zcnt, d_chunk, d_bpre;
    logic [7:0] cmd_mem [32];
    logic d_avail, d_expect;
    assign d_avail  = d_go && cfg_rsp_en && (d_ridx < cfg_rsp_n);
    assign d_expect = d_nrx < cfg_exp_len;

    always @(posedge clk) begin
        if (dev_clr) begin
            d_active <= cfg_active0; d_ready <= cfg_ready0; d_go <= 1'b0;
            d_req <= 1'b0; d_abort <= 1'b0; d_chunk_bad <= 1'b0;
            d_nrx <= 0; d_ridx <= 0; d_zcnt <= 0; d_chunk <= 0; d_bpre <= 0;
            dev_rdata <= 8'h00;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    8'h00: dev_rdata <= {1'b1, 1'b0, d_active, 5'b0};
                    8'h18: begin
                        dev_rdata <= {1'b1, d_ready, 1'b0, d_avail, d_expect, 3'b0};
                        d_chunk <= 0;
                    end
                    8'h19: dev_rdata <= (d_zcnt < cfg_zero_reads) ? 8'h00 : cfg_burst[7:0];
                    8'h1A: begin
                        dev_rdata <= (d_zcnt < cfg_zero_reads) ? 8'h00 : cfg_burst[15:8];
                        d_zcnt <= d_zcnt + 1; d_chunk <= 0;
                        if (!d_go) d_bpre <= d_bpre + 1;
                    end
                    8'h24: begin dev_rdata <= rsp_mem[d_ridx]; d_ridx <= d_ridx + 1; end
                    default: dev_rdata <= 8'hFF;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: if (bus_wdata == 8'h02) begin
                        d_req <= 1'b1;
                        if (cfg_grant) d_active <= 1'b1;
                    end
                    8'h18: begin
                        if (bus_wdata == 8'h40) begin
                            d_abort <= 1'b1;
                            if (cfg_abort_ok) d_ready <= 1'b1;
                        end
                        if (bus_wdata == 8'h20) d_go <= 1'b1;
                    end
                    8'h24: begin
                        cmd_mem[d_nrx] <= bus_wdata; d_nrx <= d_nrx + 1;
                        if (d_chunk >= int'(cfg_burst)) d_chunk_bad <= 1'b1;
                        d_chunk <= d_chunk + 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    int n_tests = 0;
    int n_fail = 0;
    int got_cyc;
    logic [2:0] got_err;
    logic [7:0] save_cmd [10] = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h98};
    logic [7:0] save_rsp [10] = '{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00};

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic dev_setup(input bit act0, input bit grant, input bit rdy0, input bit abort_ok,
                             input logic [15:0] burst, input int zeros, input int exp_len,
                             input bit rsp_en, input int rsp_n);
        cfg_active0 = act0; cfg_grant = grant; cfg_ready0 = rdy0; cfg_abort_ok = abort_ok;
        cfg_burst = burst; cfg_zero_reads = zeros; cfg_exp_len = exp_len;
        cfg_rsp_en = rsp_en; cfg_rsp_n = rsp_n;
        for (int i = 0; i < MAXR; i++) rsp_mem[i] = (i < 10) ? save_rsp[i] : 8'(i);
        for (int i = 0; i < MAXC; i++) cmd_src[i] = (i < 10) ? save_cmd[i] : 8'h00;
        @(negedge clk) dev_clr = 1'b1;
        @(negedge clk) dev_clr = 1'b0;
    endtask

    task automatic run_cmd(input int len, input int rlen, input bit hdr);
        int cyc;
        cmd_len = CW'(len); rsp_len = RW'(rlen); hdr_only = hdr;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
        chk(done == 1'b1, "R11 exchange completes", done, 1);
        got_err = err; got_cyc = cyc;
        @(negedge clk);
        chk(done == 1'b0, "R11 done lasts one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(err == got_err, "R11 err held after done", err, got_err);
    endtask

    task automatic check_cmd(input int n, input string tag);
        chk(d_nrx == n, tag, d_nrx, n);
        for (int i = 0; i < n && i < 10; i++)
            chk(cmd_mem[i] == save_cmd[i], tag, cmd_mem[i], save_cmd[i]);
    endtask

    task automatic check_rsp(input int n, input string tag);
        chk(int'(rsp_count) == n, tag, rsp_count, n);
        for (int i = 0; i < n; i++)
            chk(rsp_bytes[8*i +: 8] == save_rsp[i], tag, rsp_bytes[8*i +: 8], save_rsp[i]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(err == 3'd0, "R1 err after reset", err, 0);
        chk(rsp_count == '0, "R1 rsp_count after reset", rsp_count, 0);
        chk(!bus_rd && !bus_wr, "R1 bus quiet after reset", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_fast_path;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 10, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd0, "R8 fast path ok", got_err, 0);
        chk(d_req == 1'b0, "R2 no request when active", d_req, 0);
        chk(d_abort == 1'b0, "R4 no abort when ready", d_abort, 0);
        chk(d_chunk_bad == 1'b0, "R6 chunk within burst", d_chunk_bad, 0);
        check_cmd(10, "R6 command bytes");
        chk(d_go == 1'b1, "R7 go issued", d_go, 1);
        check_rsp(10, "R8 full reply");
    endtask

    task automatic t_slow_path;
        dev_setup(0, 1, 0, 1, 16'h0100, 3, 10, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd0, "R5 high-byte burst ok", got_err, 0);
        chk(d_req == 1'b1, "R2 locality requested", d_req, 1);
        chk(d_abort == 1'b1, "R4 abort written", d_abort, 1);
        chk(d_zcnt >= 4, "R5 zero burst retried", d_zcnt, 4);
        check_cmd(10, "R5 command bytes");
        check_rsp(10, "R8 reply slow path");
    endtask

    task automatic t_header_only;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 10, 1, 10);
        run_cmd(10, 10, 1);
        chk(got_err == 3'd0, "R9 header-only ok", got_err, 0);
        check_rsp(8, "R9 stops at chunk end");
    endtask

    task automatic t_loc_timeout;
        dev_setup(0, 0, 1, 1, 16'd4, 0, 10, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd1, "R3 locality timeout code", got_err, 1);
        chk(d_nrx == 0, "R3 nothing sent", d_nrx, 0);
        chk(got_cyc >= SHORT_T && got_cyc <= SHORT_T + 20, "R10 short window", got_cyc, SHORT_T);
    endtask

    task automatic t_ready_timeout;
        dev_setup(1, 1, 0, 0, 16'd4, 0, 10, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd2, "R4 ready timeout code", got_err, 2);
        chk(d_nrx == 0, "R4 nothing sent", d_nrx, 0);
        chk(got_cyc >= LONG_T && got_cyc <= LONG_T + 20, "R10 long window", got_cyc, LONG_T);
    endtask

    task automatic t_expect_set;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 11, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd4, "R7 expect still set code", got_err, 4);
        chk(d_go == 1'b0, "R7 no go after expect", d_go, 0);
        check_cmd(10, "R7 all bytes sent");
    endtask

    task automatic t_expect_timeout;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 0, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd3, "R6 expect timeout code", got_err, 3);
        chk(d_nrx == 4, "R6 one chunk then stall", d_nrx, 4);
    endtask

    task automatic t_rsp_timeout;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 10, 0, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd5, "R8 reply timeout code", got_err, 5);
        chk(d_go == 1'b1, "R8 go before reply wait", d_go, 1);
    endtask

    task automatic t_burst_timeout;
        dev_setup(1, 1, 1, 1, 16'd4, 100000, 10, 1, 10);
        run_cmd(10, 10, 0);
        chk(got_err == 3'd6, "R5 burst timeout code", got_err, 6);
        chk(d_nrx == 0, "R5 nothing sent", d_nrx, 0);
    endtask

    task automatic t_single_byte;
        dev_setup(1, 1, 1, 1, 16'd4, 0, 1, 1, 2);
        cmd_src[0] = 8'h5A;
        run_cmd(1, 2, 0);
        chk(got_err == 3'd0, "R12 single byte ok", got_err, 0);
        chk(d_nrx == 1, "R12 one byte sent", d_nrx, 1);
        chk(cmd_mem[0] == 8'h5A, "R12 byte value", cmd_mem[0], 8'h5A);
        chk(d_bpre == 0, "R12 no burst read before go", d_bpre, 0);
        check_rsp(2, "R12 reply");
    endtask

    initial begin
        #(8 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        dev_setup(1, 1, 1, 1, 16'd4, 0, 10, 1, 10);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_fast_path;
        t_slow_path;
        t_header_only;
        t_loc_timeout;
        t_ready_timeout;
        t_expect_set;
        t_expect_timeout;
        t_rsp_timeout;
        t_burst_timeout;
        t_single_byte;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule